// File: doc/BRIEF.md
# Burst Address Sequencer

This block holds the word address of a burst access to a pipelined synchronous SRAM and produces the array address for each beat of a four-beat burst. A burst begins when one of two active-low address strobes loads the external address. One strobe belongs to the processor and the other to the memory controller. On every later edge the advance input either steps the burst to its next beat or holds the current beat.

Only the low two address bits take part in the burst. The upper bits keep the loaded value until the next load. A static mode input picks the beat order. In interleaved order, the beat number is XORed into the start bits. In linear order, the beat number is added to the start bits modulo four. The address and a status code are registered on the rising clock edge, so they show the result of that edge's decision.

The processor strobe takes precedence over the controller strobe. The processor strobe is also masked by the first active-low chip enable. The status output reports which strobe caused a load, so both rules can be seen at the ports.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `addr_out` = 0 and `status` = 0 (idle).
- R2: The processor strobe is accepted when `proc_strobe_n` = 0 and `ce_first_n` = 0 at an edge. After that edge, `addr_out` equals the `addr_in` sampled at that edge and `status` = 1.
- R3: A controller strobe (`ctrl_strobe_n` = 0) without an accepted processor strobe loads `addr_in` at that edge, whatever the value of `ce_first_n`. After that edge, `status` = 2.
- R4: When both strobes are low and `ce_first_n` = 0, only the processor strobe acts, so `status` = 1.
- R5: When `ce_first_n` = 1, a low `proc_strobe_n` is ignored. The edge behaves as if that strobe were high: it loads through the controller strobe if that strobe is low, and otherwise it steps or holds.
- R6: After a load, an edge with no accepted strobe and `adv_n` = 0 moves the burst to the next beat, and `status` = 3.
- R7: After a load, an edge with no accepted strobe and `adv_n` = 1 leaves `addr_out` unchanged, and `status` = 4.
- R8: With `mode_interleave` = 1, beat k (k = 0..3) presents low bits equal to the start low bits XOR k. For example, start 01 gives 01, 00, 11, 10.
- R9: With `mode_interleave` = 0, beat k presents low bits equal to the start low bits + k, modulo 4. For example, start 10 gives 10, 11, 00, 01.
- R10: An advance after the fourth beat returns the low bits to the first beat's value. The upper address bits never change between loads.
- R11: After reset and before the first load, edges without an accepted strobe keep `status` = 0 and `addr_out` = 0, whatever the value of `adv_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low, has priority |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance, active low; high suspends the burst |
| ce_first_n | input | 1 | First chip enable, active low; masks the processor strobe |
| mode_interleave | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Array address of the current beat |
| status | output | 3 | 0 idle, 1 processor load, 2 controller load, 3 step, 4 hold |

## Verification
The assertions assume that `mode_interleave` does not change while a burst is running. The linear-step check compares each address with the previous one, so it would fire if the order changed in the middle of a sequence. The bench therefore changes the mode only in the cycle just before a strobe loads a new address. All inputs are driven on the falling edge, so each property sees stable values at the rising edge.

// File: rtl/burst_addr_seq_pkg.sv
// Shared types for the burst address sequencer.
package burst_addr_seq_pkg;
    // Result of one edge, also the value shown on the status port.
    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_LOAD_P = 3'd1,
        SEQ_LOAD_C = 3'd2,
        SEQ_STEP   = 3'd3,
        SEQ_HOLD   = 3'd4
    } seq_op_t;
endpackage

// File: rtl/sbs_arbiter.sv
// Decides the action for this edge from the strobes, the enable and advance.
// The processor strobe wins over the controller strobe and is masked by the
// first chip enable. Without a load, advance picks step or hold. Purely
// combinational; assumes inputs meet setup to the clock.
module sbs_arbiter
    import burst_addr_seq_pkg::*;
(
    input  logic    proc_strobe_n,
    input  logic    ctrl_strobe_n,
    input  logic    adv_n,
    input  logic    ce_first_n,
    output seq_op_t op
);
    logic proc_ok;

    // Processor strobe counts only while the first enable is asserted.
    always_comb proc_ok = !proc_strobe_n && !ce_first_n;

    // Fixed-priority choice of the edge's action.
    always_comb begin
        if (proc_ok)             op = SEQ_LOAD_P;
        else if (!ctrl_strobe_n) op = SEQ_LOAD_C;
        else if (!adv_n)         op = SEQ_STEP;
        else                     op = SEQ_HOLD;
    end
endmodule

// File: rtl/sbs_beat_counter.sv
// Holds the loaded base address, the beat number and whether a burst has
// started. A load captures the address and clears the beat. A step adds one
// to the beat, which wraps by width. Steps before the first load are dropped.
module sbs_beat_counter
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_t           op,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  beat,
    output logic              active
);
    logic is_load;

    // A load comes from either strobe.
    always_comb is_load = (op == SEQ_LOAD_P) || (op == SEQ_LOAD_C);

    // Base, beat and active registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            beat   <= '0;
            active <= 1'b0;
        end else if (is_load) begin
            base   <= addr_in;
            beat   <= '0;
            active <= 1'b1;
        end else if (active && op == SEQ_STEP) begin
            beat   <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/sbs_order_map.sv
// Maps the base and beat number to the array address. Only the low CNT_W
// bits move; interleaved XORs the beat in, linear adds it modulo the beat
// count. Assumes the mode select is static during a burst.
module sbs_order_map #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  beat,
    input  logic              mode_interleave,
    output logic [ADDR_W-1:0] addr
);
    logic [CNT_W-1:0] low_il;
    logic [CNT_W-1:0] low_lin;

    // Both candidate orderings of the low bits.
    always_comb begin
        low_il  = base[CNT_W-1:0] ^ beat;
        low_lin = base[CNT_W-1:0] + beat;
    end

    // Upper bits pass through, low bits follow the selected order.
    generate
        if (ADDR_W > CNT_W) begin : g_upper
            always_comb addr = {base[ADDR_W-1:CNT_W],
                                mode_interleave ? low_il : low_lin};
        end else begin : g_low_only
            always_comb addr = mode_interleave ? low_il : low_lin;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top. It chains the strobe arbiter, the beat
// counter and the order map, and registers the status of each edge. Status
// shows idle until the first load after reset. Assumes mode_interleave is
// static during a burst and that reset is synchronous and active low.
module burst_addr_seq
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              ce_first_n,
    input  logic              mode_interleave,
    output logic [ADDR_W-1:0] addr_out,
    output logic [2:0]        status
);
    seq_op_t           op;
    seq_op_t           status_q;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  beat;
    logic              active;

    sbs_arbiter u_arb (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .ce_first_n    (ce_first_n),
        .op            (op)
    );

    sbs_beat_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .addr_in (addr_in),
        .base    (base),
        .beat    (beat),
        .active  (active)
    );

    sbs_order_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
        .base            (base),
        .beat            (beat),
        .mode_interleave (mode_interleave),
        .addr            (addr_out)
    );

    // Status register: the action of the last edge, idle before any load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= SEQ_IDLE;
        else if (op == SEQ_LOAD_P || op == SEQ_LOAD_C || active)
            status_q <= op;
    end

    always_comb status = status_q;
endmodule

// File: rtl/burst_addr_seq_checker.sv
// Port-level properties of the burst address sequencer, bound to the top.
// Assumes mode_interleave only changes just before a load.
module burst_addr_seq_checker #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              adv_n,
    input logic              ce_first_n,
    input logic              mode_interleave,
    input logic [ADDR_W-1:0] addr_out,
    input logic [2:0]        status
);
    logic p_ok;
    logic any_load;
    logic [CNT_W-1:0] low_now;

    always_comb begin
        p_ok     = !proc_strobe_n && !ce_first_n;
        any_load = p_ok || !ctrl_strobe_n;
        low_now  = addr_out[CNT_W-1:0];
    end

    assert_proc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        p_ok |=> (addr_out == $past(addr_in)) && (status == 3'd1));

    // Covers R3, and R5 (masked processor strobe falls through).
    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_ok && !ctrl_strobe_n) |=> (addr_out == $past(addr_in)) && (status == 3'd2));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 3'd0 && !any_load && adv_n) |=> $stable(addr_out) && (status == 3'd4));

    assert_linear_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 3'd0 && !any_load && !adv_n && !mode_interleave)
        |=> (CNT_W'(low_now - $past(low_now)) == CNT_W'(1)) && (status == 3'd3));

    assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(addr_out[ADDR_W-1:CNT_W]));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && !any_load) |=> (status == 3'd0) && (addr_out == '0));
endmodule

bind burst_addr_seq burst_addr_seq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ce_first_n = 1'b1;
    logic          mode_interleave = 1'b1;
    logic [AW-1:0] addr_out;
    logic [2:0]    status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n(adv_n), .ce_first_n(ce_first_n),
        .mode_interleave(mode_interleave),
        .addr_out(addr_out), .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One edge: drive on the falling edge, sample 1 ns after the rising edge.
    task automatic edge1(input logic p, input logic c, input logic a,
                         input logic e, input logic [AW-1:0] ad);
        @(negedge clk);
        proc_strobe_n = p; ctrl_strobe_n = c; adv_n = a;
        ce_first_n = e; addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        edge1(1, 1, 0, 0, 19'h7FFFF);
        edge1(1, 1, 0, 0, 19'h7FFFF);
        check("R1 addr", addr_out, 0);
        check("R1 status", status, 0);
        @(negedge clk); rst_n = 1'b1;
        edge1(1, 1, 0, 0, 19'h12345);
        check("R11 addr", addr_out, 0);
        check("R11 status", status, 0);
        edge1(1, 1, 1, 1, 19'h00003);
        check("R11 hold addr", addr_out, 0);
        check("R11 hold status", status, 0);
    endtask

    task automatic t_interleave();
        logic [1:0] seq [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
        logic [AW-1:0] a = 19'h5A3C1;
        @(negedge clk); mode_interleave = 1'b1;
        edge1(0, 1, 1, 0, a);
        check("R2 addr", addr_out, a);
        check("R2 status", status, 1);
        for (int k = 1; k < 5; k++) begin
            edge1(1, 1, 0, 0, 19'h0);
            check("R8 beat", addr_out, {a[AW-1:2], seq[k % 4]});
            check("R6 status", status, 3);
        end
        check("R10 wrap interleaved", addr_out, a);
    endtask

    task automatic t_linear();
        logic [1:0] seq [4] = '{2'b10, 2'b11, 2'b00, 2'b01};
        logic [AW-1:0] a = 19'h3FFFE;
        @(negedge clk); mode_interleave = 1'b0;
        edge1(1, 0, 1, 1, a);
        check("R3 addr", addr_out, a);
        check("R3 status", status, 2);
        for (int k = 1; k < 5; k++) begin
            edge1(1, 1, 0, 1, 19'h7FFFF);
            check("R9 beat", addr_out, {a[AW-1:2], seq[k % 4]});
        end
        check("R10 wrap no carry", addr_out, a);
    endtask

    task automatic t_priority();
        edge1(0, 0, 1, 0, 19'h11112);
        check("R4 status", status, 1);
        check("R4 addr", addr_out, 19'h11112);
    endtask

    task automatic t_mask();
        edge1(1, 0, 1, 0, 19'h00100);
        edge1(0, 1, 0, 1, 19'h7FF00);
        check("R5 masked step addr", addr_out, 19'h00101);
        check("R5 masked step status", status, 3);
        edge1(0, 1, 1, 1, 19'h7FF00);
        check("R5 masked hold addr", addr_out, 19'h00101);
        edge1(0, 0, 1, 1, 19'h22223);
        check("R5 masked to ctrl status", status, 2);
        check("R5 masked to ctrl addr", addr_out, 19'h22223);
    endtask

    task automatic t_hold();
        edge1(1, 1, 0, 0, 19'h0);
        check("R6 step addr", addr_out, 19'h22220);
        edge1(1, 1, 1, 0, 19'h55555);
        check("R7 hold addr", addr_out, 19'h22220);
        check("R7 hold status", status, 4);
        edge1(1, 1, 1, 0, 19'h55555);
        check("R7 hold twice", addr_out, 19'h22220);
        edge1(1, 1, 0, 0, 19'h0);
        check("R6 resume", addr_out, 19'h22221);
        check("R6 resume status", status, 3);
    endtask

    initial begin
        t_reset();
        t_interleave();
        t_linear();
        t_priority();
        t_mask();
        t_hold();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule